// File: doc/BRIEF.md
# Filtered Transaction Event Counter

This block is a 64-bit performance-monitoring register for a shared cache. The low half is a 32-bit event count. The high half holds control: a set of per-attribute match masks, an encoded core-relation selector and a saturate bit. Each clock cycle the block can take one cache transaction descriptor. The descriptor names the requesting agent, whether the access is demand or prefetch, the transaction type, the snoop outcome, the coherency state of the line and which core the access is attributed to. The count steps by one only when every attribute passes its filter in that cycle.

Software reads and writes the whole 64-bit word through a single-cycle register port. The read data always shows the current register. A write takes effect at the next clock edge. Counting stays off while the whole control half is zero.

A small state machine sits behind the count and has three states:
- `ST_OFF`: the control half is zero and nothing is counted.
- `ST_RUN`: counting is active.
- `ST_PINNED`: a saturating count has reached its ceiling and holds there.

Its transitions are:
- T_ENABLE: a write with a non-zero control half. It moves OFF or PINNED to RUN, or to PINNED if the written count is already at the ceiling with saturate set.
- T_DISABLE: a write with an all-zero control half. It moves any state to OFF.
- T_PIN: a saturating increment reaches 32'hFFFFFFFF. It moves RUN to PINNED.
- T_WRAP: a non-saturating increment from 32'hFFFFFFFF to zero. It stays in RUN.
- T_HOLD: no write and no qualifying event. It stays in the present state.

Top module: `evtcnt_filter_counter`

## Requirements
- R1: After reset all 64 register bits read as zero and no transaction is counted until software writes.
- R2: While bits 63:32 are all zero, valid transactions leave the count unchanged, even if they would otherwise match.
- R3: Agent mask bits 35:32 hold one bit per requester. A transaction with agent id k (0 to 3) passes only when bit 32+k is set.
- R4: Bit 36 admits demand transactions (prefetch flag 0) and bit 37 admits prefetch transactions (prefetch flag 1).
- R5: Type mask bits 43:38 hold one bit per type. Type id t passes only when t is 0 to 5 and bit 38+t is set. Type ids 6 and 7 never pass.
- R6: Snoop mask bits 46:44 cover the snoop codes. Code 0 (clean) uses bit 44, code 1 (hit) uses bit 45 and code 2 (hit-modified) uses bit 46. Code 3 never passes.
- R7: State mask bits 53:47 hold one bit per line state. State id s passes only when s is 0 to 6 and bit 47+s is set. State id 7 never passes.
- R8: Core select bits 55:54 are compared with the core attribution input, where bit 0 means the local core and bit 1 means the other core. Select 00 passes any attribution, 01 passes only 2'b01, 10 passes only 2'b10, and 11 passes only 2'b11.
- R9: The count rises by exactly one in the cycle after a valid transaction that passes all six filters while counting is enabled. Otherwise it does not change.
- R10: With bit 59 set, the count stops at 32'hFFFFFFFF and further matches leave it there.
- R11: With bit 59 clear, a match at 32'hFFFFFFFF wraps the count to zero.
- R12: A register write in the same cycle as a matching transaction wins. The next value is exactly the written word.
- R13: Every written bit, including the unused upper bits 63:60 and 58:56, reads back unchanged until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the full register |
| reg_wr_data | input | 64 | Value to write |
| reg_rd_data | output | 64 | Current register contents |
| txn_valid | input | 1 | Descriptor present this cycle |
| txn_agent | input | 2 | Requesting agent id |
| txn_prefetch | input | 1 | 1 = prefetch, 0 = demand |
| txn_type | input | 3 | Transaction type id |
| txn_snoop | input | 2 | Snoop result code |
| txn_state | input | 3 | Line coherency state id |
| txn_core | input | 2 | Core attribution (bit 0 local, bit 1 other) |

## Verification
The assertions take two things for granted. First, reset is asserted before the first check, so the state register, the control half and the count start in agreement. Second, the descriptor inputs are driven to known values whenever the clock runs, even when `txn_valid` is low, because the filter result feeds the quiet-count property. The stimulus drives every input away from the rising edge, keeps all descriptor fields defined in idle cycles, and uses the write strobe as the only way to change the control half. That includes entering and leaving the saturated state. Out-of-range ids for type, snoop and state are driven on purpose to confirm that they never match.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

    localparam int REG_W   = 64;
    localparam int CNT_W   = 32;
    localparam int CTL_W   = REG_W - CNT_W;

    localparam int AGENT_N = 4;
    localparam int FLOW_N  = 2;
    localparam int TYPE_N  = 6;
    localparam int SNOOP_N = 3;
    localparam int STATE_N = 7;

    localparam int AGENT_IDW = $clog2(AGENT_N);
    localparam int TYPE_IDW  = 3;
    localparam int SNOOP_IDW = 2;
    localparam int STATE_IDW = 3;

    // Control half of the register, most significant field first.
    typedef struct packed {
        logic [3:0]         spare_hi;    // 63:60
        logic               saturate;    // 59
        logic [2:0]         spare_lo;    // 58:56
        logic [1:0]         core_sel;    // 55:54
        logic [STATE_N-1:0] state_msk;   // 53:47
        logic [SNOOP_N-1:0] snoop_msk;   // 46:44
        logic [TYPE_N-1:0]  type_msk;    // 43:38
        logic [FLOW_N-1:0]  flow_msk;    // 37:36
        logic [AGENT_N-1:0] agent_msk;   // 35:32
    } ctl_t;

    typedef enum logic [1:0] {
        CORE_ANY   = 2'b00,
        CORE_LOCAL = 2'b01,
        CORE_OTHER = 2'b10,
        CORE_BOTH  = 2'b11
    } core_sel_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_PINNED = 2'd2
    } cnt_state_e;

endpackage

// File: rtl/evtcnt_field_match.sv
module evtcnt_field_match #(
    parameter int W    = 4,
    parameter int ID_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]    mask,
    input  logic [ID_W-1:0] id,
    output logic            hit
);

    logic [W-1:0] sel;

    // One-hot decode of the id; ids at or above W decode to nothing.
    for (genvar i = 0; i < W; i++) begin : g_dec
        assign sel[i] = (id == ID_W'(i));
    end

    assign hit = |(sel & mask);

endmodule

// File: rtl/evtcnt_filter.sv
module evtcnt_filter
    import evtcnt_pkg::*;
(
    input  logic [AGENT_N-1:0]   agent_msk,
    input  logic [FLOW_N-1:0]    flow_msk,
    input  logic [TYPE_N-1:0]    type_msk,
    input  logic [SNOOP_N-1:0]   snoop_msk,
    input  logic [STATE_N-1:0]   state_msk,
    input  logic [1:0]           core_sel,
    input  logic                 txn_valid,
    input  logic [AGENT_IDW-1:0] txn_agent,
    input  logic                 txn_prefetch,
    input  logic [TYPE_IDW-1:0]  txn_type,
    input  logic [SNOOP_IDW-1:0] txn_snoop,
    input  logic [STATE_IDW-1:0] txn_state,
    input  logic [1:0]           txn_core,
    output logic                 hit
);

    logic agent_ok, flow_ok, type_ok, snoop_ok, state_ok, core_ok;

    evtcnt_field_match #(.W(AGENT_N), .ID_W(AGENT_IDW)) u_agent (
        .mask(agent_msk), .id(txn_agent), .hit(agent_ok));

    evtcnt_field_match #(.W(FLOW_N), .ID_W(1)) u_flow (
        .mask(flow_msk), .id(txn_prefetch), .hit(flow_ok));

    evtcnt_field_match #(.W(TYPE_N), .ID_W(TYPE_IDW)) u_type (
        .mask(type_msk), .id(txn_type), .hit(type_ok));

    evtcnt_field_match #(.W(SNOOP_N), .ID_W(SNOOP_IDW)) u_snoop (
        .mask(snoop_msk), .id(txn_snoop), .hit(snoop_ok));

    evtcnt_field_match #(.W(STATE_N), .ID_W(STATE_IDW)) u_state (
        .mask(state_msk), .id(txn_state), .hit(state_ok));

    always_comb begin
        unique case (core_sel_e'(core_sel))
            CORE_ANY:   core_ok = 1'b1;
            CORE_LOCAL: core_ok = (txn_core == 2'b01);
            CORE_OTHER: core_ok = (txn_core == 2'b10);
            CORE_BOTH:  core_ok = (txn_core == 2'b11);
            default:    core_ok = 1'b0;
        endcase
    end

    assign hit = txn_valid & agent_ok & flow_ok & type_ok
               & snoop_ok & state_ok & core_ok;

endmodule

// File: rtl/evtcnt_count_fsm.sv
module evtcnt_count_fsm
    import evtcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hit,
    output ctl_t             ctl,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_MAX1 = CNT_MAX - CNT_W'(1);

    cnt_state_e       state_q, state_d;
    ctl_t             ctl_q, ctl_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    ctl_t             wr_ctl;
    logic [CNT_W-1:0] wr_cnt;

    assign wr_ctl = ctl_t'(wr_data[REG_W-1:CNT_W]);
    assign wr_cnt = wr_data[CNT_W-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            cnt_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            cnt_q <= cnt_d;
        end
    end

    // Next-state and next-value logic
    always_comb begin
        state_d = state_q;
        ctl_d   = ctl_q;
        cnt_d   = cnt_q;
        if (wr_en) begin
            ctl_d = wr_ctl;
            cnt_d = wr_cnt;
            if (wr_ctl == '0)                             state_d = ST_OFF;
            else if (wr_ctl.saturate && wr_cnt == CNT_MAX) state_d = ST_PINNED;
            else                                          state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                end
                ST_RUN: begin
                    if (hit) begin
                        cnt_d = cnt_q + CNT_W'(1);
                        if (ctl_q.saturate && cnt_q == CNT_MAX1)
                            state_d = ST_PINNED;
                    end
                end
                ST_PINNED: begin
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    assign ctl = ctl_q;
    assign cnt = cnt_q;

    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_cnt)) && (ctl_q == $past(wr_ctl)));

    p_ctl_keep_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q));

    p_off_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && ctl_q == '0) |=> $stable(cnt_q));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !hit) |=> $stable(cnt_q));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && ctl_q.saturate && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && hit && !ctl_q.saturate && ctl_q != '0 && cnt_q == CNT_MAX)
        |=> (cnt_q == '0));

endmodule

// File: rtl/evtcnt_filter_counter.sv
module evtcnt_filter_counter
    import evtcnt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [63:0] reg_wr_data,
    output logic [63:0] reg_rd_data,
    input  logic        txn_valid,
    input  logic [1:0]  txn_agent,
    input  logic        txn_prefetch,
    input  logic [2:0]  txn_type,
    input  logic [1:0]  txn_snoop,
    input  logic [2:0]  txn_state,
    input  logic [1:0]  txn_core
);

    ctl_t             ctl;
    logic [CNT_W-1:0] cnt;
    logic             hit;

    evtcnt_filter u_filter (
        .agent_msk   (ctl.agent_msk),
        .flow_msk    (ctl.flow_msk),
        .type_msk    (ctl.type_msk),
        .snoop_msk   (ctl.snoop_msk),
        .state_msk   (ctl.state_msk),
        .core_sel    (ctl.core_sel),
        .txn_valid   (txn_valid),
        .txn_agent   (txn_agent),
        .txn_prefetch(txn_prefetch),
        .txn_type    (txn_type),
        .txn_snoop   (txn_snoop),
        .txn_state   (txn_state),
        .txn_core    (txn_core),
        .hit         (hit)
    );

    evtcnt_count_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .wr_data(reg_wr_data),
        .hit    (hit),
        .ctl    (ctl),
        .cnt    (cnt)
    );

    assign reg_rd_data = {ctl, cnt};

endmodule

// File: tb/tb_evtcnt_filter_counter.sv
`timescale 1ns/1ps
module tb_evtcnt_filter_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [63:0] reg_wr_data = '0;
    logic [63:0] reg_rd_data;
    logic        txn_valid = 1'b0;
    logic [1:0]  txn_agent = '0;
    logic        txn_prefetch = 1'b0;
    logic [2:0]  txn_type = '0;
    logic [1:0]  txn_snoop = '0;
    logic [2:0]  txn_state = '0;
    logic [1:0]  txn_core = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [63:0] model = '0;

    always #2.5 clk = ~clk;

    evtcnt_filter_counter dut (.*);

    function automatic logic [31:0] mk_ctl(bit sat, logic [1:0] core, logic [6:0] st,
                                           logic [2:0] sn, logic [5:0] ty,
                                           logic [1:0] fl, logic [3:0] ag);
        logic [31:0] c = '0;
        c[27]    = sat;
        c[23:22] = core;
        c[21:15] = st;
        c[14:12] = sn;
        c[11:6]  = ty;
        c[5:4]   = fl;
        c[3:0]   = ag;
        return c;
    endfunction

    function automatic logic [31:0] all_ctl(bit sat);
        return mk_ctl(sat, 2'b00, 7'h7F, 3'h7, 6'h3F, 2'h3, 4'hF);
    endfunction

    // Behavioural reference of the next register value.
    function automatic logic [63:0] next_model(logic [63:0] m, bit wr, logic [63:0] wd, bit v,
                                               int ag, int pf, int ty, int sn, int st, int co);
        bit ok;
        int sel;
        if (wr) return wd;
        if (m[63:32] == 0 || !v) return m;
        ok = m[32 + ag] && m[36 + pf];
        ok = ok && (ty < 6) && m[38 + (ty % 6)];
        ok = ok && (sn < 3) && m[44 + (sn % 3)];
        ok = ok && (st < 7) && m[47 + (st % 7)];
        sel = int'(m[55:54]);
        if (sel != 0 && co != sel) ok = 0;
        if (!ok) return m;
        if (m[31:0] == 32'hFFFF_FFFF) begin
            if (!m[59]) m[31:0] = 0;
        end else begin
            m[31:0] = m[31:0] + 1;
        end
        return m;
    endfunction

    task automatic check(string tag);
        total++;
        if (reg_rd_data !== model) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, reg_rd_data, model);
        end
    endtask

    task automatic step(bit wr, logic [63:0] wd, bit v, int ag, int pf, int ty,
                        int sn, int st, int co, string tag);
        logic [63:0] nx;
        reg_wr_en    = wr;
        reg_wr_data  = wd;
        txn_valid    = v;
        txn_agent    = 2'(ag);
        txn_prefetch = 1'(pf);
        txn_type     = 3'(ty);
        txn_snoop    = 2'(sn);
        txn_state    = 3'(st);
        txn_core     = 2'(co);
        nx = next_model(model, wr, wd, v, ag, pf, ty, sn, st, co);
        @(posedge clk);
        model = nx;
        @(negedge clk);
        reg_wr_en = 1'b0;
        txn_valid = 1'b0;
        check(tag);
    endtask

    task automatic wr(logic [31:0] c, logic [31:0] n, string tag);
        step(1, {c, n}, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // A transaction that passes every field when all masks are open.
    task automatic txn(int ag, int pf, int ty, int sn, int st, int co, string tag);
        step(0, '0, 1, ag, pf, ty, sn, st, co, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value");
        txn(0, 0, 0, 0, 0, 0, "R1 no count before write");

        // R2: disabled while the control half is zero
        wr(32'h0, 32'h10, "R2 load count only");
        for (int i = 0; i < 4; i++) txn(i, 0, 0, 0, 0, 0, "R2 disabled");

        // R9: everything open
        wr(all_ctl(0), 32'h0, "R9 enable");
        for (int i = 0; i < 5; i++) txn(i % 4, i % 2, i % 6, i % 3, i % 7, i % 4, "R9 open match");
        step(0, '0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");

        // R3: agent mask
        wr(mk_ctl(0, 0, 7'h7F, 3'h7, 6'h3F, 2'h3, 4'b0101), 32'h0, "R3 set");
        for (int a = 0; a < 4; a++) txn(a, 0, 0, 0, 0, 0, "R3 agent");

        // R4: flow mask
        wr(mk_ctl(0, 0, 7'h7F, 3'h7, 6'h3F, 2'b01, 4'hF), 32'h0, "R4 set demand");
        txn(0, 0, 0, 0, 0, 0, "R4 demand");
        txn(0, 1, 0, 0, 0, 0, "R4 prefetch blocked");
        wr(mk_ctl(0, 0, 7'h7F, 3'h7, 6'h3F, 2'b10, 4'hF), 32'h0, "R4 set prefetch");
        txn(0, 0, 0, 0, 0, 0, "R4 demand blocked");
        txn(0, 1, 0, 0, 0, 0, "R4 prefetch");

        // R5: type mask
        wr(mk_ctl(0, 0, 7'h7F, 3'h7, 6'b101010, 2'h3, 4'hF), 32'h0, "R5 set");
        for (int t = 0; t < 8; t++) txn(0, 0, t, 0, 0, 0, "R5 type");
        wr(all_ctl(0), 32'h0, "R5 all set");
        for (int t = 0; t < 8; t++) txn(0, 0, t, 0, 0, 0, "R5 type all");

        // R6: snoop mask
        wr(mk_ctl(0, 0, 7'h7F, 3'b101, 6'h3F, 2'h3, 4'hF), 32'h0, "R6 set");
        for (int s = 0; s < 4; s++) txn(0, 0, 0, s, 0, 0, "R6 snoop");
        wr(mk_ctl(0, 0, 7'h7F, 3'b010, 6'h3F, 2'h3, 4'hF), 32'h0, "R6 set hit");
        for (int s = 0; s < 4; s++) txn(0, 0, 0, s, 0, 0, "R6 snoop hit only");

        // R7: state mask
        wr(mk_ctl(0, 0, 7'b1001011, 3'h7, 6'h3F, 2'h3, 4'hF), 32'h0, "R7 set");
        for (int s = 0; s < 8; s++) txn(0, 0, 0, 0, s, 0, "R7 state");

        // R8: core select
        for (int sel = 0; sel < 4; sel++) begin
            wr(mk_ctl(0, 2'(sel), 7'h7F, 3'h7, 6'h3F, 2'h3, 4'hF), 32'h0, "R8 set");
            for (int c = 0; c < 4; c++) txn(0, 0, 0, 0, 0, c, "R8 core");
        end

        // R9: one mismatching field blocks the count
        wr(mk_ctl(0, 2'b01, 7'h01, 3'h1, 6'h01, 2'h1, 4'h1), 32'h100, "R9 narrow");
        txn(0, 0, 0, 0, 0, 1, "R9 all match");
        txn(1, 0, 0, 0, 0, 1, "R9 agent miss");
        txn(0, 1, 0, 0, 0, 1, "R9 flow miss");
        txn(0, 0, 1, 0, 0, 1, "R9 type miss");
        txn(0, 0, 0, 1, 0, 1, "R9 snoop miss");
        txn(0, 0, 0, 0, 1, 1, "R9 state miss");
        txn(0, 0, 0, 0, 0, 2, "R9 core miss");
        step(0, '0, 0, 0, 0, 0, 0, 0, 1, "R9 valid low");

        // R10: saturation
        wr(all_ctl(1), 32'hFFFF_FFFD, "R10 set");
        for (int i = 0; i < 5; i++) txn(0, 0, 0, 0, 0, 0, "R10 saturate");

        // R11: wrap
        wr(all_ctl(0), 32'hFFFF_FFFE, "R11 set");
        for (int i = 0; i < 3; i++) txn(0, 0, 0, 0, 0, 0, "R11 wrap");

        // R12: write wins over a matching transaction
        step(1, {all_ctl(0), 32'h55}, 1, 0, 0, 0, 0, 0, 0, "R12 write wins");
        txn(0, 0, 0, 0, 0, 0, "R12 after write");
        step(1, {all_ctl(1), 32'hFFFF_FFFF}, 1, 0, 0, 0, 0, 0, 0, "R12 write pinned");
        step(1, {all_ctl(1), 32'h7}, 1, 0, 0, 0, 0, 0, 0, "R12 leave pinned");
        txn(0, 0, 0, 0, 0, 0, "R12 counts again");
        step(1, 64'h0, 1, 0, 0, 0, 0, 0, 0, "R2 disable by write");
        txn(0, 0, 0, 0, 0, 0, "R2 disabled again");

        // R13: spare bits read back
        wr(32'hF700_0000 | all_ctl(0), 32'hABCD, "R13 spare bits");
        for (int i = 0; i < 3; i++) step(0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, "R13 hold");
        wr(32'hF000_0000, 32'h1, "R13 spare only enables");
        txn(3, 1, 5, 2, 6, 3, "R13 no mask passes");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule